// File: doc/BRIEF.md
# Latchable Bidirectional Parity Transceiver

The block joins two byte-wide buses, A and B, each carrying its own parity bit. Both sides have a holding register that acts as a latch. While the side's latch enable is high, the register reloads on every clock edge; while it is low, the register keeps its word. Two active-low output enables pick which bus, if any, the block drives. The driven bus receives the data held by the opposite side's latch. With the mode input low, that data leaves with freshly generated parity. With the mode input high, the parity bit held beside the data passes through unchanged (feed-through). A single select input chooses even or odd parity for every generator and checker in the block.

Each side has its own active-low error flag. The flag compares the parity its latch holds with the parity computed from the data in that same latch, so checking goes on in every mode, including feed-through and with both outputs off. When a side is being driven, its latch loads the outgoing word instead of the value on its bus input. If that latch is open, the outgoing word and parity loop back into it, and the destination flag checks what was sent while the source flag checks what arrived.

The buses are split into separate input, output and output-valid signals. The block sits directly on the pins, so there is no valid/ready handshake and no back-pressure: a word moves whenever a latch is open, and the output-valid signals show only which side is driven. The latch registers are the only state, and reset clears them to zero.

Top module: `ptx_transceiver`

## Requirements
- R1: Driving follows the two active-low enables. oe_a_n=0 with oe_b_n=1 drives bus A only (a_oe=1), and oe_a_n=1 with oe_b_n=0 drives bus B only (b_oe=1). With both high, neither bus is driven. With both low, the state is illegal and B-direction driving wins: b_oe=1 and a_oe=0.
- R2: A side's latch register loads on a rising clock edge while its enable (le_a or le_b) is high, and holds its word while the enable is low.
- R3: With mode_pass=0 and par_odd=0, the parity driven on the active output equals the XOR of the eight source-latch data bits.
- R4: With mode_pass=1, the parity driven on the active output equals the parity bit held in the source latch.
- R5: The data on a driven output equals the data held in the opposite side's latch. An output that is not driven reads all zeros, with parity 0.
- R6: err_a_n (err_b_n) is 0 exactly when the side's latched parity bit differs from the XOR of its latched data bits and par_odd. This holds in every mode and output-enable state.
- R7: While a side is driven, its latch loads the outgoing data and parity rather than its bus input. With that latch open, its error flag checks the transmitted word.
- R8: After reset, both latches hold zero, neither bus is driven, and both error flags are 1 while par_odd=0.
- R9: par_odd=1 inverts every generated parity bit (odd parity), and the error flags then check against odd parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oe_a_n | input | 1 | Drive enable for bus A, active low |
| oe_b_n | input | 1 | Drive enable for bus B, active low |
| mode_pass | input | 1 | 0 = generate parity, 1 = pass the stored parity through |
| par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| le_a | input | 1 | A latch open (high) or holding (low) |
| le_b | input | 1 | B latch open (high) or holding (low) |
| a_in | input | 8 | Data arriving from bus A |
| a_par_in | input | 1 | Parity arriving from bus A |
| a_out | output | 8 | Data driven onto bus A |
| a_par_out | output | 1 | Parity driven onto bus A |
| a_oe | output | 1 | Bus A is driven |
| b_in | input | 8 | Data arriving from bus B |
| b_par_in | input | 1 | Parity arriving from bus B |
| b_out | output | 8 | Data driven onto bus B |
| b_par_out | output | 1 | Parity driven onto bus B |
| b_oe | output | 1 | Bus B is driven |
| err_a_n | output | 1 | A-side parity error, active low |
| err_b_n | output | 1 | B-side parity error, active low |

## Verification
Two checks can land in the same cycle: the source flag judging a received word and the destination flag judging the word just sent back through its own open latch. The bench sets this up by holding a direction with both latches open for two edges. It injects a parity fault on the source side alone, on the destination's ignored input alone, or on both. In feed-through mode a bad parity must appear on both flags. In generate mode it must appear only on the source flag. Every combination of enables, latch states, mode and parity sense is swept, and the bench tracks the expected latch contents itself, so latches closed from an earlier step are judged on the word they are still holding.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_A2B  = 2'd1,
    DIR_B2A  = 2'd2
  } dir_t;
endpackage

// File: rtl/ptx_parity.sv
module ptx_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] data,
  input  logic         odd,
  output logic         par
);
  // even: parity bit makes the total count of ones even
  assign par = (^data) ^ odd;
endmodule

// File: rtl/ptx_side_latch.sv
module ptx_side_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] d_in,
  input  logic         p_in,
  output logic [W-1:0] q_d,
  output logic         q_p
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_d <= '0;
      q_p <= 1'b0;
    end else if (le) begin
      q_d <= d_in;
      q_p <= p_in;
    end
  end
endmodule

// File: rtl/ptx_dir_ctrl.sv
module ptx_dir_ctrl
  import ptx_pkg::*;
(
  input  logic oe_a_n,
  input  logic oe_b_n,
  output dir_t dir
);
  // both enables low is illegal: driving bus B takes priority
  always_comb begin
    if (!oe_b_n)      dir = DIR_A2B;
    else if (!oe_a_n) dir = DIR_B2A;
    else              dir = DIR_NONE;
  end
endmodule

// File: rtl/ptx_transceiver.sv
module ptx_transceiver
  import ptx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oe_a_n,
  input  logic         oe_b_n,
  input  logic         mode_pass,
  input  logic         par_odd,
  input  logic         le_a,
  input  logic         le_b,
  input  logic [W-1:0] a_in,
  input  logic         a_par_in,
  output logic [W-1:0] a_out,
  output logic         a_par_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  input  logic         b_par_in,
  output logic [W-1:0] b_out,
  output logic         b_par_out,
  output logic         b_oe,
  output logic         err_a_n,
  output logic         err_b_n
);
  localparam int NSIDE = 2;   // index 0 = A side, 1 = B side

  dir_t                      dir;
  logic [NSIDE-1:0]          drv;
  logic [NSIDE-1:0]          le;
  logic [NSIDE-1:0][W-1:0]   bus_d;
  logic [NSIDE-1:0]          bus_p;
  logic [NSIDE-1:0][W-1:0]   lat_d;
  logic [NSIDE-1:0]          lat_p;
  logic [NSIDE-1:0][W-1:0]   q_d;
  logic [NSIDE-1:0]          q_p;
  logic [NSIDE-1:0]          gen_p;
  logic [NSIDE-1:0]          tx_p;
  logic [NSIDE-1:0]          err_n;
  logic [W:0]                lat_q_a;
  logic [W:0]                lat_q_b;

  ptx_dir_ctrl u_dir (
    .oe_a_n (oe_a_n),
    .oe_b_n (oe_b_n),
    .dir    (dir)
  );

  assign drv   = {dir == DIR_A2B, dir == DIR_B2A};
  assign le    = {le_b, le_a};
  assign bus_d = {b_in, a_in};
  assign bus_p = {b_par_in, a_par_in};

  genvar s;
  generate
    for (s = 0; s < NSIDE; s++) begin : g_side
      localparam int O = NSIDE - 1 - s;

      ptx_parity #(.W(W)) u_par (
        .data (q_d[s]),
        .odd  (par_odd),
        .par  (gen_p[s])
      );

      // parity this side sends when it is the source
      assign tx_p[s]  = mode_pass ? q_p[s] : gen_p[s];
      assign err_n[s] = ~(q_p[s] ^ gen_p[s]);

      // a driven side loads the word being sent onto it
      assign lat_d[s] = drv[s] ? q_d[O]  : bus_d[s];
      assign lat_p[s] = drv[s] ? tx_p[O] : bus_p[s];

      ptx_side_latch #(.W(W)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (le[s]),
        .d_in  (lat_d[s]),
        .p_in  (lat_p[s]),
        .q_d   (q_d[s]),
        .q_p   (q_p[s])
      );
    end
  endgenerate

  assign a_oe      = drv[0];
  assign b_oe      = drv[1];
  assign a_out     = drv[0] ? q_d[1]  : '0;
  assign a_par_out = drv[0] ? tx_p[1] : 1'b0;
  assign b_out     = drv[1] ? q_d[0]  : '0;
  assign b_par_out = drv[1] ? tx_p[0] : 1'b0;
  assign err_a_n   = err_n[0];
  assign err_b_n   = err_n[1];

  assign lat_q_a = {q_p[0], q_d[0]};
  assign lat_q_b = {q_p[1], q_d[1]};
endmodule

// File: rtl/ptx_transceiver_chk.sv
module ptx_transceiver_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         oe_b_n,
  input logic         mode_pass,
  input logic         par_odd,
  input logic         le_a,
  input logic         le_b,
  input logic [W-1:0] a_in,
  input logic         a_par_in,
  input logic         a_oe,
  input logic [W-1:0] b_out,
  input logic         b_par_out,
  input logic         b_oe,
  input logic         err_b_n,
  input logic [W:0]   lat_q_a,
  input logic [W:0]   lat_q_b
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_oe_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_oe && b_oe));

  assert_b_priority_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_b_n |-> (b_oe && !a_oe));

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && le_a && !a_oe) |=> (lat_q_a == $past({a_par_in, a_in})));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !le_a) |=> $stable(lat_q_a));

  assert_gen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (b_oe && !mode_pass) |-> (b_par_out == ((^b_out) ^ par_odd)));

  assert_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (b_oe && mode_pass) |-> (b_par_out == lat_q_a[W]));

  assert_loopback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && le_b && b_oe) |=> (lat_q_b == $past({b_par_out, b_out})));

  assert_loop_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(b_oe && !mode_pass && le_b) && $stable(par_odd)) |-> err_b_n);
endmodule

bind ptx_transceiver ptx_transceiver_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .oe_b_n    (oe_b_n),
  .mode_pass (mode_pass),
  .par_odd   (par_odd),
  .le_a      (le_a),
  .le_b      (le_b),
  .a_in      (a_in),
  .a_par_in  (a_par_in),
  .a_oe      (a_oe),
  .b_out     (b_out),
  .b_par_out (b_par_out),
  .b_oe      (b_oe),
  .err_b_n   (err_b_n),
  .lat_q_a   (lat_q_a),
  .lat_q_b   (lat_q_b)
);

// File: tb/ptx_transceiver_tb.sv
module ptx_transceiver_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oe_a_n = 1'b1, oe_b_n = 1'b1, mode_pass = 1'b0, par_odd = 1'b0;
  logic le_a = 1'b0, le_b = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic a_par_in = 1'b0, b_par_in = 1'b0;
  logic [W-1:0] a_out, b_out;
  logic a_par_out, b_par_out, a_oe, b_oe, err_a_n, err_b_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ptx_transceiver #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .mode_pass(mode_pass), .par_odd(par_odd), .le_a(le_a), .le_b(le_b),
    .a_in(a_in), .a_par_in(a_par_in), .a_out(a_out), .a_par_out(a_par_out),
    .a_oe(a_oe), .b_in(b_in), .b_par_in(b_par_in), .b_out(b_out),
    .b_par_out(b_par_out), .b_oe(b_oe), .err_a_n(err_a_n), .err_b_n(err_b_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // expected latch contents, tracked from the requirements
  logic [W-1:0] ea_d = '0, eb_d = '0;
  logic         ea_p = 1'b0, eb_p = 1'b0;

  function automatic logic gp(input logic [W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 a_oe", a_oe, 0);
    chk("R8 b_oe", b_oe, 0);
    chk("R8 a_out", {a_par_out, a_out}, 0);
    chk("R8 b_out", {b_par_out, b_out}, 0);
    chk("R8 err_a_n", err_a_n, 1);
    chk("R8 err_b_n", err_b_n, 1);

    for (int it = 0; it < 256; it++) begin
      logic [1:0] oe;
      logic pass, odd, la, lb, fa, fb, drv_a, drv_b;
      logic [W-1:0] da, db;
      logic [W-1:0] ex_a_out, ex_b_out;
      logic ex_a_par, ex_b_par;
      string ptag, dtag_a, dtag_b, etag_a, etag_b;
      oe   = it[1:0];
      pass = it[2];
      odd  = it[3];
      la   = it[4];
      lb   = it[5];
      fa   = it[6];
      fb   = it[7];
      da   = W'((it * 37 + 11) & 8'hFF);
      db   = W'((it * 91 + 5) & 8'hFF);

      @(negedge clk);
      oe_a_n = oe[0]; oe_b_n = oe[1];
      mode_pass = pass; par_odd = odd; le_a = la; le_b = lb;
      a_in = da; a_par_in = gp(da, odd) ^ fa;
      b_in = db; b_par_in = gp(db, odd) ^ fb;
      repeat (2) @(posedge clk);
      #1;

      // R1 direction: bus B wins when both enables are low
      drv_b = !oe[1];
      drv_a = !oe[0] && oe[1];
      if (drv_b) begin
        if (la) begin ea_d = da; ea_p = a_par_in; end
        if (lb) begin eb_d = ea_d; eb_p = pass ? ea_p : gp(ea_d, odd); end
      end else if (drv_a) begin
        if (lb) begin eb_d = db; eb_p = b_par_in; end
        if (la) begin ea_d = eb_d; ea_p = pass ? eb_p : gp(eb_d, odd); end
      end else begin
        if (la) begin ea_d = da; ea_p = a_par_in; end
        if (lb) begin eb_d = db; eb_p = b_par_in; end
      end

      ex_a_out = drv_a ? eb_d : '0;
      ex_b_out = drv_b ? ea_d : '0;
      ex_a_par = drv_a ? (pass ? eb_p : gp(eb_d, odd)) : 1'b0;
      ex_b_par = drv_b ? (pass ? ea_p : gp(ea_d, odd)) : 1'b0;

      ptag   = pass ? "R4 parity out" : (odd ? "R9 parity out" : "R3 parity out");
      dtag_a = lb ? "R5 a_out" : "R2 a_out held source";
      dtag_b = la ? "R5 b_out" : "R2 b_out held source";
      etag_a = (drv_a && la) ? "R7 err_a_n loopback" : "R6 err_a_n";
      etag_b = (drv_b && lb) ? "R7 err_b_n loopback" : "R6 err_b_n";

      chk("R1 a_oe", a_oe, drv_a);
      chk("R1 b_oe", b_oe, drv_b);
      chk(dtag_a, a_out, ex_a_out);
      chk(dtag_b, b_out, ex_b_out);
      chk({ptag, " A"}, a_par_out, ex_a_par);
      chk({ptag, " B"}, b_par_out, ex_b_par);
      chk(etag_a, err_a_n, !(ea_p != gp(ea_d, odd)));
      chk(etag_b, err_b_n, !(eb_p != gp(eb_d, odd)));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule